// File: doc/BRIEF.md
# Keyboard Command Responder Queue

This block stands in for the host-facing side of a serial keyboard. Key events arrive as a 7-bit scancode plus a press/release flag and are stored as single bytes in a circular queue. The host drains that queue one byte at a time through a read strobe. A flag shows whether any byte is waiting.

Command bytes from the host arrive on a separate strobe. A reset command or an identify command empties the queue and loads a fixed reply in a single clock. An LED command arms a flag so that the following command byte is taken as LED data and is otherwise ignored.

The queue depth is a parameter, 16 by default and at least 4. Both pointers wrap modulo the depth, so the depth does not need to be a power of two.

Top module: `kbd_reply_queue`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the queue and clears the LED-pending flag. Afterwards `count` is 0, `rx_avail` is 0 and `rd_data` is 0x00.
- R2: Command 0x01, when no LED byte is pending, empties the queue and leaves the three bytes 0xFF, 0x04, 0x7F in it, in that read order (`count` = 3).
- R3: Command 0x07 or 0x0F, when no LED byte is pending, empties the queue and leaves 0xFE then 0x21 in it (`count` = 2).
- R4: Command 0x0E sets the LED-pending flag. The next command byte, whatever its value, only clears that flag and leaves the queue untouched. The command byte after that is decoded normally.
- R5: Any other command value, when no LED byte is pending, leaves the queue unchanged.
- R6: A key event enqueues `{key_release, key_code}`: bit 7 is 1 for a release and 0 for a press, and bits 6:0 are the scancode.
- R7: A key event while `count` equals the depth is dropped. The count stays at the depth and the stored bytes are unchanged.
- R8: `rd_data` is 0x00 while the queue is empty. A read strobe on an empty queue changes nothing: the next byte pushed is the next byte read.
- R9: `rd_data` always shows the oldest byte. A read strobe removes it at the clock edge. `rx_avail` is high exactly while `count` is non-zero, so it stays high after a pop that leaves entries behind.
- R10: The read and write pointers wrap modulo the depth, so bytes come out in push order across the wrap point.
- R11: A command that loads a reply takes priority over everything else in the same cycle. A key event and a read strobe in that cycle are discarded.
- R12: A key event and a read strobe in the same cycle both take effect, and `count` is unchanged. If the queue is full at that edge, the key event is still dropped and only the pop happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Scancode of the key event |
| key_release | input | 1 | 1 = release, 0 = press |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest queued byte, 0x00 when empty |
| rx_avail | output | 1 | High while the queue holds data |
| count | output | $clog2(DEPTH+1) | Number of queued bytes |

## Verification
Every change to the queue, to the count and to the LED-pending flag takes effect at the first rising edge after the strobe that causes it. `rd_data` and `rx_avail` follow that state combinationally, so a pushed byte becomes visible one edge after its key strobe. A reply's first byte is likewise visible one edge after the command. The bench applies each stimulus for exactly one edge and samples all outputs at the following falling edge, half a cycle later. The value a read will return is compared before the read strobe is applied.

// File: rtl/kbd_reply_queue.sv
module kbd_reply_queue #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [7:0]                 cmd_byte,
  input  logic                       key_valid,
  input  logic [6:0]                 key_code,
  input  logic                       key_release,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  output logic                       rx_avail,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;
  logic          led_pend;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire cmd_live = cmd_valid & ~led_pend;
  wire is_rst   = cmd_live & (cmd_byte == 8'h01);
  wire is_id    = cmd_live & ((cmd_byte == 8'h07) | (cmd_byte == 8'h0F));
  wire is_led   = cmd_live & (cmd_byte == 8'h0E);
  wire reply    = is_rst | is_id;
  wire empty    = (cnt == '0);
  wire do_pop   = rd_en & ~empty & ~reply;
  wire do_push  = key_valid & ~reply & (cnt != FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      wptr     <= '0;
      cnt      <= '0;
      led_pend <= 1'b0;
    end else begin
      if (cmd_valid) led_pend <= is_led;
      if (reply) begin
        rptr <= '0;
        wptr <= is_rst ? PW'(3) : PW'(2);
        cnt  <= is_rst ? CW'(3) : CW'(2);
      end else begin
        if (do_push) wptr <= step(wptr);
        if (do_pop)  rptr <= step(rptr);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (reply) begin
        mem[0] <= is_rst ? 8'hFF : 8'hFE;
        mem[1] <= is_rst ? 8'h04 : 8'h21;
        mem[2] <= 8'h7F;
      end else if (do_push) begin
        mem[wptr] <= {key_release, key_code};
      end
    end
  end

  assign rd_data  = empty ? 8'h00 : mem[rptr];
  assign rx_avail = ~empty;
  assign count    = cnt;

  // R7
  full_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  // R2
  reset_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !led_pend && cmd_byte == 8'h01) |=> (count == CW'(3) && rd_data == 8'hFF));

  // R4
  led_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && led_pend && !key_valid && !rd_en) |=> (!led_pend && count == $past(count)));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count == '0 && !cmd_valid && !key_valid) |=> (count == '0 && rd_data == 8'h00));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (key_valid && !rd_en && !cmd_valid && count == FULL) |=> (count == FULL && $stable(rd_data)));

  // R9
  pop_left_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count > CW'(1) && !cmd_valid && !key_valid) |=> (rx_avail && count == $past(count) - 1'b1));
endmodule

// File: tb/kbd_reply_queue_bench.sv
`timescale 1ns/1ps
module kbd_reply_queue_bench;
  localparam int BD = 16;
  localparam int CW = $clog2(BD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, key_valid = 1'b0, key_release = 1'b0, rd_en = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [6:0] key_code = 7'h00;
  logic [7:0] rd_data;
  logic rx_avail;
  logic [CW-1:0] count;

  kbd_reply_queue #(.DEPTH(BD)) u_kbd_reply_queue (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_code(key_code), .key_release(key_release),
    .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail), .count(count));

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [7:0] mq [BD];
  int mr = 0, mw = 0, mc = 0;
  bit mled = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_head();
    return (mc == 0) ? 0 : int'(mq[mr]);
  endfunction

  task automatic m_reset();
    mr = 0; mw = 0; mc = 0; mled = 0;
  endtask

  task automatic m_step(bit cv, logic [7:0] cb, bit kv, logic [6:0] kc, bit kr, bit rd);
    bit live = cv && !mled;
    bit rs = live && cb == 8'h01;
    bit id = live && (cb == 8'h07 || cb == 8'h0F);
    bit push, pop;
    if (cv) mled = live && cb == 8'h0E;
    if (rs || id) begin
      mq[0] = rs ? 8'hFF : 8'hFE;
      mq[1] = rs ? 8'h04 : 8'h21;
      mq[2] = 8'h7F;
      mr = 0; mw = rs ? 3 : 2; mc = mw;
    end else begin
      push = kv && mc < BD;
      pop  = rd && mc != 0;
      if (push) begin mq[mw] = {kr, kc}; mw = (mw + 1) % BD; end
      if (pop) mr = (mr + 1) % BD;
      mc = mc + int'(push) - int'(pop);
    end
  endtask

  task automatic check_model(string tag);
    chk({tag, " count"}, int'(count), mc);
    chk({tag, " rx_avail"}, int'(rx_avail), int'(mc != 0));
    chk({tag, " rd_data"}, int'(rd_data), m_head());
  endtask

  task automatic drive(bit cv, logic [7:0] cb, bit kv, logic [6:0] kc, bit kr, bit rd);
    cmd_valid = cv; cmd_byte = cb; key_valid = kv; key_code = kc;
    key_release = kr; rd_en = rd;
    m_step(cv, cb, kv, kc, kr, rd);
    @(posedge clk); #1;
    cmd_valid = 0; key_valid = 0; rd_en = 0;
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] b);  drive(1, b, 0, 0, 0, 0); endtask
  task automatic key(logic [6:0] c, bit r); drive(0, 0, 1, c, r, 0); endtask
  task automatic pop_exp(string tag, int exp);
    chk(tag, int'(rd_data), exp);
    drive(0, 0, 0, 0, 0, 1);
  endtask

  task automatic do_reset();
    rst = 1; m_reset();
    @(posedge clk); #1; rst = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(posedge clk);
    do_reset();
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 rx_avail", int'(rx_avail), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R6 press / release encoding
    key(7'h1C, 0); key(7'h1C, 1);
    pop_exp("R6 press", 8'h1C);
    pop_exp("R6 release", 8'h9C);

    // R2 reset reply flushes old data
    key(7'h11, 0); key(7'h12, 0);
    cmd(8'h01);
    chk("R2 count", int'(count), 3);
    pop_exp("R2 byte0", 8'hFF);
    chk("R9 rx_avail after pop", int'(rx_avail), 1);
    pop_exp("R2 byte1", 8'h04);
    pop_exp("R2 byte2", 8'h7F);
    chk("R9 rx_avail drained", int'(rx_avail), 0);

    // R3 identify replies
    key(7'h05, 0);
    cmd(8'h07);
    chk("R3 count 07", int'(count), 2);
    pop_exp("R3 07 byte0", 8'hFE);
    cmd(8'h0F);
    chk("R3 count 0F", int'(count), 2);
    pop_exp("R3 0F byte0", 8'hFE);
    pop_exp("R3 0F byte1", 8'h21);

    // R4 LED argument skip
    key(7'h05, 0);
    cmd(8'h0E);
    cmd(8'h01);
    chk("R4 skipped count", int'(count), 1);
    chk("R4 skipped head", int'(rd_data), 8'h05);
    cmd(8'h01);
    chk("R4 decoded again", int'(count), 3);

    // R5 unknown command
    cmd(8'h02);
    chk("R5 count", int'(count), 3);
    chk("R5 head", int'(rd_data), 8'hFF);

    // R8 empty read
    repeat (3) drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 1);
    chk("R8 empty count", int'(count), 0);
    chk("R8 empty data", int'(rd_data), 0);
    key(7'h33, 0);
    pop_exp("R8 after empty read", 8'h33);

    // R7 / R10 fill, overflow and wrap
    for (int i = 0; i < BD; i++) key(7'(i + 64), 0);
    chk("R7 full count", int'(count), BD);
    key(7'h7E, 1);
    chk("R7 dropped count", int'(count), BD);
    for (int i = 0; i < BD; i++) pop_exp("R10 order", i + 64);
    chk("R10 empty after wrap", int'(count), 0);

    // R11 reply wins
    key(7'h01, 0);
    drive(1, 8'h01, 1, 7'h22, 0, 1);
    chk("R11 count", int'(count), 3);
    chk("R11 head", int'(rd_data), 8'hFF);

    // R12 push and pop together
    drive(0, 0, 1, 7'h44, 0, 1);
    chk("R12 count", int'(count), 3);
    chk("R12 head", int'(rd_data), 8'h04);
    for (int i = 0; i < BD - 3; i++) key(7'(i), 0);
    drive(0, 0, 1, 7'h55, 0, 1);
    chk("R12 full pop only", int'(count), BD - 1);

    // R1 reset clears LED flag mid-run
    cmd(8'h0E);
    do_reset();
    chk("R1 count after reset", int'(count), 0);
    cmd(8'h01);
    chk("R1 led flag cleared", int'(count), 3);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [7:0] cb;
      case ($urandom_range(0, 4))
        0: cb = 8'h01;
        1: cb = 8'h07;
        2: cb = 8'h0E;
        3: cb = 8'h0F;
        default: cb = 8'($urandom);
      endcase
      drive(sel == 0, cb, $urandom_range(0, 2) != 0, 7'($urandom), 1'($urandom),
            $urandom_range(0, 2) == 0);
      check_model("RND");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule